// File: doc/BRIEF.md
# Address watchpoint match unit

This block is a debug watchpoint checker. Software programs up to four watched addresses, a control word and a status word through an indexed register port. Every cycle the unit compares the presented memory access (start address, byte count and kind) against each armed slot. A slot matches when the access kind agrees with the slot's type setting and at least one byte of the access falls inside the slot's aligned watched window.

When any slot matches, the unit latches the matching slots into sticky status bits and raises a one-cycle trap strobe on the next cycle. Two event inputs, a single-step strobe and a task-switch strobe, also set sticky status bits. A task switch also disarms every slot that relied only on its per-task (local) enable, while the persistent (global) enables are kept.

Top module: `wpt_unit`

## Requirements
- R1: After reset the four address registers and the control register read 0, the status register reads 0xFFFF0FF0 and `trap_o` is low.
- R2: Indices 0 to 3 are the slot address registers and read back what was written. Indices 4 and 5 always read 0, and writes to them change no register.
- R3: The control register sits at index 7. Its bits 10 to 15 always read 0. Bits 8 and 9 are stored and read back but have no other effect. All other bits read back as written.
- R4: The status register sits at index 6. A read returns ones at every bit of mask 0xFFFF0FF0, the slot trap bits in [3:0], the single-step bit in [14] and the task-switch bit in [15]. A write loads bits [3:0], 14 and 15 from the write data, so writing 0 clears them.
- R5: Control bit 2s is slot s's local enable and bit 2s+1 is its global enable. A slot can match only when at least one of the two is set.
- R6: Slot s's type sits in control bits [16+4s+1 : 16+4s]. Type 00 matches only fetches, 01 matches only writes, 11 matches reads and writes, and 10 never matches. The `acc_kind` codes are 00 fetch, 01 read and 10 write. Code 11 matches no slot.
- R7: Slot s's length sits in control bits [16+4s+3 : 16+4s+2]. The codes are 00 for 1 byte, 01 for 2, 11 for 4 and 10 for 8. The watched window starts at the slot address with its low bits cleared to that length's alignment.
- R8: The access covers 2^`acc_size` bytes starting at `acc_addr`. A slot matches if any of those bytes lies in its window, including accesses that begin before the window.
- R9: `trap_o` is high for exactly the one cycle after a valid access matches at least one slot. At the same clock edge, the status bits of every matching slot are set together.
- R10: Status trap bits are sticky. A later non-matching access leaves them set, a new match adds its slot bits, and only a status write clears them.
- R11: A `evt_tswitch` pulse clears control bits 0, 2, 4 and 6, leaves bits 1, 3, 5 and 7 unchanged, and sets status bit 15.
- R12: A `evt_step` pulse sets status bit 14, which is sticky in the same way as the trap bits.
- R13: When `acc_valid` is low, no slot matches, whatever the other access inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | 3 | Register index for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_idx` (combinational) |
| acc_valid | input | 1 | Access present this cycle |
| acc_addr | input | 32 | Access start byte address |
| acc_size | input | 2 | Log2 of the access byte count |
| acc_kind | input | 2 | Access kind: 00 fetch, 01 read, 10 write |
| evt_step | input | 1 | Single-step event pulse |
| evt_tswitch | input | 1 | Task-switch event pulse |
| trap_o | output | 1 | One-cycle trap strobe |

## Verification
The hardest situations to reach are those where the overlap test and the length alignment interact. One is a slot address that is not aligned to its length. Another is an access that begins below the window and reaches into it. A third is a wide access that ends exactly one byte short of the window. The stimulus programs a slot at a deliberately unaligned address, then steps the access start across each edge of the window with several access sizes. The same-cycle case is also hard: two slots watching one address, together with a task switch while both enable kinds are set. The stimulus builds it by loading the control word with all enables before pulsing the event.

// File: rtl/wpt_pkg.sv
package wpt_pkg;
  localparam int REG_W     = 32;
  localparam int NSLOT     = 4;
  localparam int IDX_W     = 3;
  localparam int FIELD_W   = 4;
  localparam int FIELD_LSB = 16;
  localparam int EN_W      = 2 * NSLOT;

  localparam logic [IDX_W-1:0] STAT_IDX = 3'd6;
  localparam logic [IDX_W-1:0] CTRL_IDX = 3'd7;

  localparam int STEP_BIT = 14;
  localparam int TSW_BIT  = 15;

  localparam logic [REG_W-1:0] STAT_ONES = 32'hFFFF_0FF0;
  localparam logic [REG_W-1:0] CTRL_KEEP = 32'hFFFF_03FF;
  localparam logic [EN_W-1:0]  GLOBAL_EN = 8'hAA;

  typedef enum logic [1:0] {
    KIND_FETCH = 2'b00,
    KIND_READ  = 2'b01,
    KIND_WRITE = 2'b10,
    KIND_NONE  = 2'b11
  } acc_kind_e;

  typedef enum logic [1:0] {
    WT_EXEC  = 2'b00,
    WT_WRITE = 2'b01,
    WT_NEVER = 2'b10,
    WT_RDWR  = 2'b11
  } watch_type_e;

  function automatic logic [3:0] window_bytes(input logic [1:0] len_code);
    logic [3:0] n;
    case (len_code)
      2'b00:   n = 4'd1;
      2'b01:   n = 4'd2;
      2'b11:   n = 4'd4;
      default: n = 4'd8;
    endcase
    return n;
  endfunction
endpackage

// File: rtl/wpt_rst_sync.sv
module wpt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/wpt_slot_cmp.sv
module wpt_slot_cmp
  import wpt_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0]  slot_addr,
  input  logic [FIELD_W-1:0] slot_field,
  input  logic               slot_armed,
  input  logic               acc_valid,
  input  logic [ADDR_W-1:0]  acc_addr,
  input  logic [1:0]         acc_size,
  input  logic [1:0]         acc_kind,
  output logic               hit
);
  localparam int XW = ADDR_W + 1;

  logic [XW-1:0]     win_len;
  logic [ADDR_W-1:0] align_mask;
  logic [XW-1:0]     win_first;
  logic [XW-1:0]     win_last;
  logic [XW-1:0]     acc_len;
  logic [XW-1:0]     acc_first;
  logic [XW-1:0]     acc_last;
  logic              overlap;
  logic              kind_ok;
  watch_type_e       wtype;

  always_comb begin
    win_len    = {{(XW-4){1'b0}}, window_bytes(slot_field[3:2])};
    align_mask = ~(win_len[ADDR_W-1:0] - {{(ADDR_W-1){1'b0}}, 1'b1});
    win_first  = {1'b0, slot_addr & align_mask};
    win_last   = win_first + win_len - {{(XW-1){1'b0}}, 1'b1};
    acc_len    = {{(XW-1){1'b0}}, 1'b1} << acc_size;
    acc_first  = {1'b0, acc_addr};
    acc_last   = acc_first + acc_len - {{(XW-1){1'b0}}, 1'b1};
    overlap    = (acc_first <= win_last) && (acc_last >= win_first);
  end

  always_comb begin
    wtype = watch_type_e'(slot_field[1:0]);
    case (wtype)
      WT_EXEC:  kind_ok = (acc_kind == KIND_FETCH);
      WT_WRITE: kind_ok = (acc_kind == KIND_WRITE);
      WT_RDWR:  kind_ok = (acc_kind == KIND_READ) || (acc_kind == KIND_WRITE);
      default:  kind_ok = 1'b0;
    endcase
  end

  assign hit = acc_valid && slot_armed && kind_ok && overlap;
endmodule

// File: rtl/wpt_ctrl_reg.sv
module wpt_ctrl_reg
  import wpt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  input  logic             tswitch,
  output logic [REG_W-1:0] ctrl_q
);
  logic [REG_W-1:0] ctrl_d;
  logic             ctrl_ld;

  always_comb begin
    ctrl_d  = ctrl_q;
    ctrl_ld = wr_en || tswitch;
    if (wr_en)   ctrl_d = wdata & CTRL_KEEP;
    if (tswitch) ctrl_d[EN_W-1:0] = ctrl_d[EN_W-1:0] & GLOBAL_EN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_ld) ctrl_q <= ctrl_d;
  end
endmodule

// File: rtl/wpt_stat_reg.sv
module wpt_stat_reg
  import wpt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [NSLOT-1:0] wr_trap,
  input  logic             wr_step,
  input  logic             wr_tsw,
  input  logic [NSLOT-1:0] hit_vec,
  input  logic             step_evt,
  input  logic             tsw_evt,
  output logic [NSLOT-1:0] trap_bits,
  output logic             step_bit,
  output logic             tsw_bit,
  output logic             trap_o
);
  logic [NSLOT-1:0] trap_d;
  logic             step_d;
  logic             tsw_d;
  logic             stat_ld;
  logic             strobe_d;

  always_comb begin
    trap_d = wr_en ? wr_trap : trap_bits;
    step_d = wr_en ? wr_step : step_bit;
    tsw_d  = wr_en ? wr_tsw  : tsw_bit;
    trap_d = trap_d | hit_vec;
    step_d = step_d | step_evt;
    tsw_d  = tsw_d  | tsw_evt;
    stat_ld  = wr_en || (|hit_vec) || step_evt || tsw_evt;
    strobe_d = |hit_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trap_bits <= '0;
      step_bit  <= 1'b0;
      tsw_bit   <= 1'b0;
    end else if (stat_ld) begin
      trap_bits <= trap_d;
      step_bit  <= step_d;
      tsw_bit   <= tsw_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trap_o <= 1'b0;
    else        trap_o <= strobe_d;
  end
endmodule

// File: rtl/wpt_unit.sv
module wpt_unit
  import wpt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [IDX_W-1:0] reg_idx,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             acc_valid,
  input  logic [REG_W-1:0] acc_addr,
  input  logic [1:0]       acc_size,
  input  logic [1:0]       acc_kind,
  input  logic             evt_step,
  input  logic             evt_tswitch,
  output logic             trap_o
);
  logic                         rst_sync_n;
  logic [NSLOT-1:0][REG_W-1:0]  addr_q;
  logic [NSLOT-1:0]             addr_ld;
  logic [REG_W-1:0]             ctrl_q;
  logic [NSLOT-1:0]             hit_vec;
  logic [NSLOT-1:0]             trap_bits;
  logic                         step_bit;
  logic                         tsw_bit;
  logic                         stat_wr;
  logic                         ctrl_wr;
  logic [REG_W-1:0]             stat_word;

  wpt_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    for (int i = 0; i < NSLOT; i++) begin
      addr_ld[i] = reg_wr && (reg_idx == IDX_W'(i));
    end
    stat_wr = reg_wr && (reg_idx == STAT_IDX);
    ctrl_wr = reg_wr && (reg_idx == CTRL_IDX);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      addr_q <= '0;
    end else begin
      for (int i = 0; i < NSLOT; i++) begin
        if (addr_ld[i]) addr_q[i] <= reg_wdata;
      end
    end
  end

  wpt_ctrl_reg u_ctrl (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (ctrl_wr),
    .wdata   (reg_wdata),
    .tswitch (evt_tswitch),
    .ctrl_q  (ctrl_q)
  );

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    wpt_slot_cmp #(.ADDR_W(REG_W)) u_cmp (
      .slot_addr  (addr_q[s]),
      .slot_field (ctrl_q[FIELD_LSB + FIELD_W*s +: FIELD_W]),
      .slot_armed (ctrl_q[2*s] | ctrl_q[2*s+1]),
      .acc_valid  (acc_valid),
      .acc_addr   (acc_addr),
      .acc_size   (acc_size),
      .acc_kind   (acc_kind),
      .hit        (hit_vec[s])
    );
  end

  wpt_stat_reg u_stat (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en     (stat_wr),
    .wr_trap   (reg_wdata[NSLOT-1:0]),
    .wr_step   (reg_wdata[STEP_BIT]),
    .wr_tsw    (reg_wdata[TSW_BIT]),
    .hit_vec   (hit_vec),
    .step_evt  (evt_step),
    .tsw_evt   (evt_tswitch),
    .trap_bits (trap_bits),
    .step_bit  (step_bit),
    .tsw_bit   (tsw_bit),
    .trap_o    (trap_o)
  );

  always_comb begin
    stat_word              = STAT_ONES;
    stat_word[NSLOT-1:0]   = trap_bits;
    stat_word[STEP_BIT]    = step_bit;
    stat_word[TSW_BIT]     = tsw_bit;
  end

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NSLOT; i++) begin
      if (reg_idx == IDX_W'(i)) reg_rdata = addr_q[i];
    end
    if (reg_idx == STAT_IDX) reg_rdata = stat_word;
    if (reg_idx == CTRL_IDX) reg_rdata = ctrl_q;
  end
endmodule

// File: rtl/wpt_unit_chk.sv
module wpt_unit_chk
  import wpt_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic [IDX_W-1:0] reg_idx,
  input logic [REG_W-1:0] reg_rdata,
  input logic             acc_valid,
  input logic             evt_step,
  input logic             evt_tswitch,
  input logic             trap_o,
  input logic [REG_W-1:0] ctrl_q,
  input logic [NSLOT-1:0] trap_bits,
  input logic             step_bit
);
  logic stat_wr_c;
  logic ctrl_wr_c;
  assign stat_wr_c = reg_wr && (reg_idx == STAT_IDX);
  assign ctrl_wr_c = reg_wr && (reg_idx == CTRL_IDX);

  // R4
  stat_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_idx == STAT_IDX) |-> ((reg_rdata & STAT_ONES) == STAT_ONES));

  // R3
  ctrl_resv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_idx == CTRL_IDX) |-> (reg_rdata[15:10] == 6'd0));

  // R9
  trap_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> $past(acc_valid));

  // R10
  trap_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_wr_c |=> ((trap_bits & $past(trap_bits)) == $past(trap_bits)));

  // R11
  tsw_local_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_tswitch |=> ((ctrl_q[EN_W-1:0] & ~GLOBAL_EN) == '0));

  // R11
  tsw_global_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_tswitch && !ctrl_wr_c) |=>
      ((ctrl_q[EN_W-1:0] & GLOBAL_EN) == ($past(ctrl_q[EN_W-1:0]) & GLOBAL_EN)));

  // R12
  step_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_step |=> step_bit);
endmodule

bind wpt_unit wpt_unit_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .reg_wr      (reg_wr),
  .reg_idx     (reg_idx),
  .reg_rdata   (reg_rdata),
  .acc_valid   (acc_valid),
  .evt_step    (evt_step),
  .evt_tswitch (evt_tswitch),
  .trap_o      (trap_o),
  .ctrl_q      (ctrl_q),
  .trap_bits   (trap_bits),
  .step_bit    (step_bit)
);

// File: tb/wpt_unit_tb_top.sv
module wpt_unit_tb_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [2:0]  reg_idx;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        acc_valid;
  logic [31:0] acc_addr;
  logic [1:0]  acc_size;
  logic [1:0]  acc_kind;
  logic        evt_step;
  logic        evt_tswitch;
  logic        trap_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  logic [31:0] m_addr [4];
  logic [31:0] m_ctrl;
  logic [3:0]  m_trap;
  logic        m_step;
  logic        m_tsw;

  always #(CLK_P/2) clk = ~clk;

  wpt_unit dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_valid(acc_valid),
    .acc_addr(acc_addr), .acc_size(acc_size), .acc_kind(acc_kind),
    .evt_step(evt_step), .evt_tswitch(evt_tswitch), .trap_o(trap_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] idx, output logic [31:0] val);
    reg_idx = idx;
    #1;
    val = reg_rdata;
  endtask

  task automatic wr(input logic [2:0] idx, input logic [31:0] val);
    @(negedge clk);
    reg_wr = 1'b1; reg_idx = idx; reg_wdata = val;
    @(negedge clk);
    reg_wr = 1'b0;
    if (idx < 3'd4) m_addr[idx[1:0]] = val;
    if (idx == 3'd7) m_ctrl = val & 32'hFFFF03FF;
    if (idx == 3'd6) begin
      m_trap = val[3:0]; m_step = val[14]; m_tsw = val[15];
    end
  endtask

  function automatic logic [31:0] exp_stat();
    logic [31:0] v;
    v = 32'hFFFF0FF0;
    v[3:0] = m_trap; v[14] = m_step; v[15] = m_tsw;
    return v;
  endfunction

  function automatic logic [3:0] model_hits(input logic [31:0] a, input logic [1:0] sz,
                                            input logic [1:0] k);
    logic [3:0] h;
    longint wl, wb, af, al;
    logic [3:0] fld;
    logic type_ok;
    h = '0;
    for (int s = 0; s < 4; s++) begin
      fld = m_ctrl[16 + 4*s +: 4];
      case (fld[3:2])
        2'b00: wl = 1; 2'b01: wl = 2; 2'b11: wl = 4; default: wl = 8;
      endcase
      wb = longint'(m_addr[s]) - (longint'(m_addr[s]) % wl);
      af = longint'(a);
      al = af + (longint'(1) << sz) - 1;
      case (fld[1:0])
        2'b00: type_ok = (k == 2'b00);
        2'b01: type_ok = (k == 2'b10);
        2'b11: type_ok = (k == 2'b01) || (k == 2'b10);
        default: type_ok = 1'b0;
      endcase
      h[s] = (m_ctrl[2*s] | m_ctrl[2*s+1]) && type_ok && (af <= wb + wl - 1) && (al >= wb);
    end
    return h;
  endfunction

  // Drives one access, checks the strobe one cycle later, the status and the strobe's end.
  task automatic access(input string req, input logic [31:0] a, input logic [1:0] sz,
                        input logic [1:0] k, input logic vld, input logic exp_hit);
    logic [3:0] h;
    logic [31:0] v;
    h = vld ? model_hits(a, sz, k) : 4'h0;
    @(negedge clk);
    acc_valid = vld; acc_addr = a; acc_size = sz; acc_kind = k;
    @(negedge clk);
    acc_valid = 1'b0;
    m_trap = m_trap | h;
    chk({req, " trap strobe"}, {31'd0, trap_o}, {31'd0, exp_hit});
    chk({req, " model agrees"}, {31'd0, (h != 0)}, {31'd0, exp_hit});
    rd(3'd6, v);
    chk({req, " status"}, v, exp_stat());
    @(negedge clk);
    chk({req, " strobe one cycle (R9)"}, {31'd0, trap_o}, 32'd0);
  endtask

  task automatic clear_stat();
    wr(3'd6, 32'h0);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int i = 0; i < 4; i++) begin
      rd(3'(i), v); chk("R1 addr reset", v, 32'h0);
    end
    rd(3'd7, v); chk("R1 ctrl reset", v, 32'h0);
    rd(3'd6, v); chk("R1 status reset", v, 32'hFFFF0FF0);
    chk("R1 trap reset", {31'd0, trap_o}, 32'd0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    for (int i = 0; i < 4; i++) wr(3'(i), 32'hA5000000 + 32'(i * 17));
    for (int i = 0; i < 4; i++) begin
      rd(3'(i), v); chk("R2 addr readback", v, 32'hA5000000 + 32'(i * 17));
    end
    wr(3'd4, 32'hDEADBEEF); wr(3'd5, 32'h12345678);
    rd(3'd4, v); chk("R2 idx4 reads zero", v, 32'h0);
    rd(3'd5, v); chk("R2 idx5 reads zero", v, 32'h0);
    for (int i = 0; i < 4; i++) begin
      rd(3'(i), v); chk("R2 idx4/5 write ignored", v, 32'hA5000000 + 32'(i * 17));
    end
    rd(3'd7, v); chk("R2 ctrl untouched", v, 32'h0);
    wr(3'd7, 32'hFFFFFFFF);
    rd(3'd7, v); chk("R3 ctrl reserved zero", v, 32'hFFFF03FF);
    wr(3'd7, 32'h12340300);
    rd(3'd7, v); chk("R3 slowdown stored", v, 32'h12340300);
    wr(3'd7, 32'h0);
    wr(3'd6, 32'h0000C00F);
    rd(3'd6, v); chk("R4 status write sets", v, 32'hFFFFCFFF);
    wr(3'd6, 32'hFFFFFFFF);
    rd(3'd6, v); chk("R4 status reserved ones", v, 32'hFFFFCFFF);
    clear_stat();
    rd(3'd6, v); chk("R4 status write clears", v, 32'hFFFF0FF0);
  endtask

  task automatic t_enables();
    wr(3'd0, 32'h0000_1000);
    wr(3'd7, 32'h0000_0003 << 16);
    access("R5 disarmed", 32'h1000, 2'd0, 2'b01, 1'b1, 1'b0);
    wr(3'd7, (32'h3 << 16) | 32'h1);
    access("R5 local enable", 32'h1000, 2'd0, 2'b01, 1'b1, 1'b1);
    clear_stat();
    wr(3'd7, (32'h3 << 16) | 32'h2);
    access("R5 global enable", 32'h1000, 2'd0, 2'b01, 1'b1, 1'b1);
    clear_stat();
    access("R13 valid low", 32'h1000, 2'd0, 2'b01, 1'b0, 1'b0);
  endtask

  task automatic t_types();
    wr(3'd0, 32'h0000_0100);
    wr(3'd7, (32'h0 << 16) | 32'h1);
    access("R6 exec/fetch", 32'h100, 2'd0, 2'b00, 1'b1, 1'b1); clear_stat();
    access("R6 exec/read", 32'h100, 2'd0, 2'b01, 1'b1, 1'b0);
    wr(3'd7, (32'h1 << 16) | 32'h1);
    access("R6 write/write", 32'h100, 2'd0, 2'b10, 1'b1, 1'b1); clear_stat();
    access("R6 write/read", 32'h100, 2'd0, 2'b01, 1'b1, 1'b0);
    wr(3'd7, (32'h3 << 16) | 32'h1);
    access("R6 rw/read", 32'h100, 2'd0, 2'b01, 1'b1, 1'b1); clear_stat();
    access("R6 rw/fetch", 32'h100, 2'd0, 2'b00, 1'b1, 1'b0);
    access("R6 rw/kind11", 32'h100, 2'd0, 2'b11, 1'b1, 1'b0);
    wr(3'd7, (32'h2 << 16) | 32'h1);
    access("R6 type10 never", 32'h100, 2'd0, 2'b10, 1'b1, 1'b0);
  endtask

  task automatic t_lengths();
    wr(3'd1, 32'h0000_2005);
    wr(3'd7, (32'hF << 20) | 32'h4);
    access("R7 len4 low edge", 32'h2004, 2'd0, 2'b01, 1'b1, 1'b1); clear_stat();
    access("R7 len4 high edge", 32'h2007, 2'd0, 2'b01, 1'b1, 1'b1); clear_stat();
    access("R7 len4 above", 32'h2008, 2'd0, 2'b01, 1'b1, 1'b0);
    access("R7 len4 below", 32'h2003, 2'd0, 2'b01, 1'b1, 1'b0);
    wr(3'd7, (32'hB << 20) | 32'h4);
    access("R7 len8 base", 32'h2000, 2'd0, 2'b10, 1'b1, 1'b1); clear_stat();
    access("R7 len8 above", 32'h2008, 2'd0, 2'b10, 1'b1, 1'b0);
    wr(3'd7, (32'h7 << 20) | 32'h4);
    access("R7 len2 inside", 32'h2004, 2'd0, 2'b10, 1'b1, 1'b1); clear_stat();
    access("R7 len2 outside", 32'h2006, 2'd0, 2'b10, 1'b1, 1'b0);
  endtask

  task automatic t_overlap();
    wr(3'd2, 32'h0000_3000);
    wr(3'd7, (32'h3 << 24) | 32'h20);
    access("R8 4B straddle", 32'h2FFE, 2'd2, 2'b01, 1'b1, 1'b1); clear_stat();
    access("R8 8B short", 32'h2FF8, 2'd3, 2'b01, 1'b1, 1'b0);
    access("R8 8B reach", 32'h2FFC, 2'd3, 2'b01, 1'b1, 1'b1); clear_stat();
    access("R8 2B short", 32'h2FFE, 2'd1, 2'b01, 1'b1, 1'b0);
  endtask

  task automatic t_multi_sticky();
    logic [31:0] v;
    wr(3'd0, 32'h0000_4000); wr(3'd3, 32'h0000_4000);
    wr(3'd7, (32'h3 << 28) | (32'h3 << 16) | 32'h81);
    access("R9 two slots same cycle", 32'h4000, 2'd0, 2'b01, 1'b1, 1'b1);
    rd(3'd6, v); chk("R9 both bits", {28'd0, v[3:0]}, 32'h9);
    access("R10 miss keeps bits", 32'h5000, 2'd0, 2'b01, 1'b1, 1'b0);
    rd(3'd6, v); chk("R10 sticky", {28'd0, v[3:0]}, 32'h9);
    clear_stat();
    rd(3'd6, v); chk("R10 cleared by write", v, 32'hFFFF0FF0);
  endtask

  task automatic t_events();
    logic [31:0] v;
    wr(3'd7, 32'h0000_00FF);
    @(negedge clk); evt_tswitch = 1'b1;
    @(negedge clk); evt_tswitch = 1'b0;
    m_ctrl = m_ctrl & ~32'h55; m_tsw = 1'b1;
    rd(3'd7, v); chk("R11 locals cleared", v, 32'h0000_00AA);
    rd(3'd6, v); chk("R11 status bit15", v, 32'hFFFF8FF0);
    @(negedge clk); evt_step = 1'b1;
    @(negedge clk); evt_step = 1'b0;
    m_step = 1'b1;
    rd(3'd6, v); chk("R12 status bit14", v, 32'hFFFFCFF0);
    repeat (3) @(negedge clk);
    rd(3'd6, v); chk("R12 step sticky", v, 32'hFFFFCFF0);
  endtask

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_idx = '0; reg_wdata = '0;
    acc_valid = 1'b0; acc_addr = '0; acc_size = '0; acc_kind = '0;
    evt_step = 1'b0; evt_tswitch = 1'b0;
    for (int i = 0; i < 4; i++) m_addr[i] = '0;
    m_ctrl = '0; m_trap = '0; m_step = 1'b0; m_tsw = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_regs();
    t_enables();
    t_types();
    t_lengths();
    t_overlap();
    t_multi_sticky();
    t_events();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule